// File: doc/BRIEF.md
# Single-Port Synchronous RAM with Output Preset

This block is a single-port memory with a registered read port. On every rising clock edge where the clock enable is high, it does one of three things: it stores a word, it fetches a word into the output register, or it loads the output register with a fixed constant. The constant is a parameter. Loading it never changes the stored words.

When the clock enable is low, both the array and the output register are frozen. A separate power-up constant sets what the output register shows before the first enabled edge.

A parameter sets what the output register shows on a write. It can show the word just written, the word that was at that address before the write, or it can keep its previous value. The array is a plain synchronous-write memory, and the output register has one cycle of latency. This fits the on-chip memory of an FPGA-style device.

Top module: `sync_ram_sr`

## Requirements
- R1: Before the first enabled clock edge, `rd_data` equals POWERUP_VAL (default 8'hC3). POWERUP_VAL may differ from PRESET_VAL.
- R2: An edge with `clk_en`=1 and `out_preset`=1 loads PRESET_VAL (default 8'h5A) into `rd_data` after that edge. This happens whatever the values of `addr` and `wr_data`.
- R3: A preset edge with `wr_en`=0 leaves every stored word unchanged. A later read returns the earlier contents.
- R4: An edge with `clk_en`=0 changes neither the output register nor any stored word, whatever the values of `wr_en`, `out_preset`, `addr` and `wr_data`.
- R5: An enabled edge with `wr_en`=0 and `out_preset`=0 loads the word at `addr` into `rd_data`, visible after that edge.
- R6: An enabled edge with `wr_en`=1 stores `wr_data` at `addr`.
- R7: With WR_MODE = WM_WRITE_FIRST (the default), an enabled write edge with `out_preset`=0 puts `wr_data` on `rd_data` after that edge.
- R8: If `wr_en` and `out_preset` are both 1 on an enabled edge, the word is still stored, while `rd_data` takes PRESET_VAL. The preset has priority for the output.
- R9: With WR_MODE = WM_READ_FIRST, an enabled write edge with `out_preset`=0 puts the word previously stored at `addr` on `rd_data`.
- R10: With WR_MODE = WM_NO_CHANGE, an enabled write edge with `out_preset`=0 leaves `rd_data` unchanged, while the word is still stored.
- R11: The address width is clog2(DEPTH). Every location from 0 to DEPTH-1 holds an independent word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clk_en | input | 1 | Clock enable; low freezes array and output |
| wr_en | input | 1 | Store `wr_data` at `addr` on an enabled edge |
| out_preset | input | 1 | Load PRESET_VAL into the output register on an enabled edge |
| addr | input | clog2(DEPTH) | Word address |
| wr_data | input | WIDTH | Data to store |
| rd_data | output | WIDTH | Registered output word |

## Verification
On every cycle, the assertions check three things about the output register: that a preset loads the constant, that a disabled edge holds it, and that the write-mode rule applies for the configured mode (new data, or unchanged). The checker keeps no model of the array. Three kinds of behaviour are therefore shown only by the bench's scenarios: reads returning stored words, a preset or a disabled edge leaving memory intact, and full-depth addressing. The bench also runs read-first and no-change instances beside the default one, to show the old-data output and that writes still land under a no-change output.

// File: rtl/sram_pkg.sv
package sram_pkg;

  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wr_mode_e;

  typedef enum logic [1:0] {
    OUT_HOLD   = 2'd0,
    OUT_MEM    = 2'd1,
    OUT_WDATA  = 2'd2,
    OUT_PRESET = 2'd3
  } out_sel_e;

endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter sram_pkg::wr_mode_e WR_MODE = sram_pkg::WM_WRITE_FIRST
) (
  input  logic                clk_en,
  input  logic                wr_en,
  input  logic                out_preset,
  output logic                mem_we,
  output sram_pkg::out_sel_e  out_sel
);
  import sram_pkg::*;

  out_sel_e write_sel;

  generate
    if (WR_MODE == WM_READ_FIRST) begin : g_rf
      assign write_sel = OUT_MEM;
    end else if (WR_MODE == WM_NO_CHANGE) begin : g_nc
      assign write_sel = OUT_HOLD;
    end else begin : g_wf
      assign write_sel = OUT_WDATA;
    end
  endgenerate

  // array write is independent of the preset; output follows priority
  assign mem_we = clk_en & wr_en;

  always_comb begin
    if (!clk_en)         out_sel = OUT_HOLD;
    else if (out_preset) out_sel = OUT_PRESET;
    else if (wr_en)      out_sel = write_sel;
    else                 out_sel = OUT_MEM;
  end

endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rd_word
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // pre-write contents; registered by the output stage
  assign rd_word = mem[addr];

endmodule

// File: rtl/sram_outreg.sv
module sram_outreg #(
  parameter int               WIDTH       = 8,
  parameter logic [WIDTH-1:0] PRESET_VAL  = '0,
  parameter logic [WIDTH-1:0] POWERUP_VAL = '0
) (
  input  logic               clk,
  input  sram_pkg::out_sel_e sel,
  input  logic [WIDTH-1:0]   mem_word,
  input  logic [WIDTH-1:0]   wdata,
  output logic [WIDTH-1:0]   q
);
  import sram_pkg::*;

  logic [WIDTH-1:0] q_r = POWERUP_VAL;

  always_ff @(posedge clk) begin
    case (sel)
      OUT_PRESET: q_r <= PRESET_VAL;
      OUT_MEM:    q_r <= mem_word;
      OUT_WDATA:  q_r <= wdata;
      default:    q_r <= q_r;
    endcase
  end

  assign q = q_r;

endmodule

// File: rtl/sync_ram_sr.sv
module sync_ram_sr #(
  parameter int                   WIDTH       = 8,
  parameter int                   DEPTH       = 16,
  parameter logic [WIDTH-1:0]     PRESET_VAL  = 8'h5A,
  parameter logic [WIDTH-1:0]     POWERUP_VAL = 8'hC3,
  parameter sram_pkg::wr_mode_e   WR_MODE     = sram_pkg::WM_WRITE_FIRST,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             clk_en,
  input  logic             wr_en,
  input  logic             out_preset,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data
);

  logic               mem_we;
  sram_pkg::out_sel_e out_sel;
  logic [WIDTH-1:0]   mem_word;

  sram_ctrl #(.WR_MODE(WR_MODE)) u_ctrl (
    .clk_en     (clk_en),
    .wr_en      (wr_en),
    .out_preset (out_preset),
    .mem_we     (mem_we),
    .out_sel    (out_sel)
  );

  sram_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .we      (mem_we),
    .addr    (addr),
    .wdata   (wr_data),
    .rd_word (mem_word)
  );

  sram_outreg #(
    .WIDTH(WIDTH), .PRESET_VAL(PRESET_VAL), .POWERUP_VAL(POWERUP_VAL)
  ) u_out (
    .clk      (clk),
    .sel      (out_sel),
    .mem_word (mem_word),
    .wdata    (wr_data),
    .q        (rd_data)
  );

endmodule

// File: rtl/sync_ram_sr_chk.sv
module sync_ram_sr_chk #(
  parameter int                 WIDTH      = 8,
  parameter logic [WIDTH-1:0]   PRESET_VAL = '0,
  parameter sram_pkg::wr_mode_e WR_MODE    = sram_pkg::WM_WRITE_FIRST
) (
  input logic             clk,
  input logic             clk_en,
  input logic             wr_en,
  input logic             out_preset,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] rd_data
);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  AST_PRESET_LOADS: assert property (@(posedge clk) disable iff (!armed)
    (clk_en && out_preset) |=> (rd_data == PRESET_VAL)); // R2

  AST_PRESET_OVER_WRITE: assert property (@(posedge clk) disable iff (!armed)
    (clk_en && out_preset && wr_en) |=> (rd_data == PRESET_VAL)); // R8

  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!armed)
    (!clk_en) |=> $stable(rd_data)); // R4

  generate
    if (WR_MODE == sram_pkg::WM_WRITE_FIRST) begin : g_wf
      AST_WRITE_SHOWS_NEW: assert property (@(posedge clk) disable iff (!armed)
        (clk_en && wr_en && !out_preset) |=> (rd_data == $past(wr_data))); // R7
    end else if (WR_MODE == sram_pkg::WM_NO_CHANGE) begin : g_nc
      AST_WRITE_KEEPS_OUT: assert property (@(posedge clk) disable iff (!armed)
        (clk_en && wr_en && !out_preset) |=> $stable(rd_data)); // R10
    end
  endgenerate

endmodule

bind sync_ram_sr sync_ram_sr_chk #(
  .WIDTH(WIDTH), .PRESET_VAL(PRESET_VAL), .WR_MODE(WR_MODE)
) u_chk (
  .clk        (clk),
  .clk_en     (clk_en),
  .wr_en      (wr_en),
  .out_preset (out_preset),
  .wr_data    (wr_data),
  .rd_data    (rd_data)
);

// File: tb/sync_ram_sr_test.sv
module sync_ram_sr_test;
  localparam int W  = 8;
  localparam int D  = 16;
  localparam int AW = $clog2(D);
  localparam logic [W-1:0] PV = 8'h5A;
  localparam logic [W-1:0] UV = 8'hC3;

  logic clk = 1'b0;
  logic clk_en = 1'b0, wr_en = 1'b0, out_preset = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wr_data = '0;
  logic [W-1:0]  q_wf, q_rf, q_nc;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  sync_ram_sr #(.WIDTH(W), .DEPTH(D), .PRESET_VAL(PV), .POWERUP_VAL(UV)) uut (
    .clk(clk), .clk_en(clk_en), .wr_en(wr_en), .out_preset(out_preset),
    .addr(addr), .wr_data(wr_data), .rd_data(q_wf));

  sync_ram_sr #(.WIDTH(W), .DEPTH(D), .PRESET_VAL(PV), .POWERUP_VAL(UV),
                .WR_MODE(sram_pkg::WM_READ_FIRST)) uut_rf (
    .clk(clk), .clk_en(clk_en), .wr_en(wr_en), .out_preset(out_preset),
    .addr(addr), .wr_data(wr_data), .rd_data(q_rf));

  sync_ram_sr #(.WIDTH(W), .DEPTH(D), .PRESET_VAL(PV), .POWERUP_VAL(UV),
                .WR_MODE(sram_pkg::WM_NO_CHANGE)) uut_nc (
    .clk(clk), .clk_en(clk_en), .wr_en(wr_en), .out_preset(out_preset),
    .addr(addr), .wr_data(wr_data), .rd_data(q_nc));

  // {req, en, we, pre, addr, data, expected on default instance}
  localparam int VW = 4 + 3 + AW + 2 * W;
  localparam int NV = 12;
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd7,  3'b110, 4'd3, 8'h11, 8'h11},  // R7 write shows new data
    {4'd6,  3'b110, 4'd7, 8'h22, 8'h22},  // R6 store
    {4'd5,  3'b100, 4'd3, 8'hFF, 8'h11},  // R5 read back
    {4'd2,  3'b101, 4'd7, 8'h99, 8'h5A},  // R2 preset ignores addr/data
    {4'd3,  3'b100, 4'd7, 8'h00, 8'h22},  // R3 memory intact after preset
    {4'd4,  3'b010, 4'd7, 8'h77, 8'h22},  // R4 disabled write: output held
    {4'd4,  3'b100, 4'd7, 8'h00, 8'h22},  // R4 disabled write: memory held
    {4'd4,  3'b001, 4'd3, 8'h00, 8'h22},  // R4 disabled preset
    {4'd8,  3'b111, 4'd5, 8'h44, 8'h5A},  // R8 preset wins output
    {4'd8,  3'b100, 4'd5, 8'h00, 8'h44},  // R8 write still stored
    {4'd7,  3'b110, 4'd3, 8'h66, 8'h66},  // R7 overwrite
    {4'd5,  3'b100, 4'd3, 8'h00, 8'h66}   // R5 read after overwrite
  };

  task automatic step(input logic e, input logic w, input logic p,
                      input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    clk_en = e; wr_en = w; out_preset = p; addr = a; wr_data = d;
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : watchdog
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    #5;
    // R1 power-up value on all variants
    check("R1 wf", q_wf, UV);
    check("R1 rf", q_rf, UV);
    check("R1 nc", q_nc, UV);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      step(v[VW-5], v[VW-6], v[VW-7], v[2*W+AW-1 -: AW], v[2*W-1 -: W]);
      checks++;
      if (q_wf !== v[W-1:0]) begin
        errors++;
        $display("FAIL R%0d vector %0d: actual=%h expected=%h",
                 v[VW-1 -: 4], i, q_wf, v[W-1:0]);
      end
    end

    // write-mode variants
    step(1, 0, 1, 0, 8'h00);
    check("R2 rf", q_rf, PV);
    check("R2 nc", q_nc, PV);
    step(1, 1, 0, 2, 8'h10);
    check("R7 wf", q_wf, 8'h10);
    check("R10 nc hold", q_nc, PV);
    step(1, 1, 0, 2, 8'h20);
    check("R9 rf old data", q_rf, 8'h10);
    check("R10 nc hold again", q_nc, PV);
    step(1, 0, 0, 2, 8'h00);
    check("R10 nc stored", q_nc, 8'h20);
    check("R9 rf stored", q_rf, 8'h20);

    // R11 full depth, including 0 and DEPTH-1
    for (int i = 0; i < D; i++) step(1, 1, 0, AW'(i), W'(i * 13 + 3));
    for (int i = D - 1; i >= 0; i--) begin
      step(1, 0, 0, AW'(i), 8'h00);
      check("R11 wf", q_wf, W'(i * 13 + 3));
      check("R11 rf", q_rf, W'(i * 13 + 3));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule